// File: doc/BRIEF.md
# Serial Character Transmitter with Parity and Break Control

This block turns one parallel byte at a time into an asynchronous serial frame on a single output line. The line sits at logic 1 while nothing is being sent. When a byte is handed over through a valid/ready handshake, the block sends a low start bit, then the eight data bits starting with the least significant, then an optional parity bit, and finally a high stop bit. Each bit lasts from one baud tick to the next. The baud tick is a single-cycle enable pulse made outside the block.

A small set of line-control inputs shapes each frame. One input turns the parity bit on or off. A two-bit mode input picks odd parity, even parity, a parity bit forced to 1, or a parity bit forced to 0. These inputs are captured when a byte is accepted, so software may change them freely while a frame is on the wire.

A separate break input pulls the line low at once and keeps it low for as long as the input is held, whatever the frame sequencer is doing. The sequencer keeps counting baud ticks underneath the break. When the break is released, the frame in progress carries on from the bit position it has reached.

Top module: `serial_tx_core`

## Requirements
- R1: After reset, `txd` is 1 and `tx_ready` is 1 while `brk_force` is low.
- R2: A byte is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle, `tx_ready` stays 0 until the frame has ended.
- R3: The first bit of a frame is a start bit of value 0. It is followed by the 8 data bits, least significant bit first.
- R4: With `par_en` = 0, no parity bit is sent, and the stop bit directly follows data bit 7 (10 bit periods in all).
- R5: With `par_en` = 1 and `par_sel` = 0 (odd), the parity bit makes the number of ones in the data bits plus the parity bit odd.
- R6: With `par_en` = 1 and `par_sel` = 1 (even), the parity bit makes that count even.
- R7: With `par_en` = 1 and `par_sel` = 2, the parity bit is 1 whatever the data.
- R8: With `par_en` = 1 and `par_sel` = 3, the parity bit is 0 whatever the data.
- R9: The last bit of every frame is a stop bit of value 1. On the cycle after the baud tick that ends it, `tx_ready` is 1 and the line is idle high.
- R10: While `brk_force` is 1, `txd` is 0 on every cycle, both when idle and during a frame.
- R11: A break does not stop or reset the sequencer. After `brk_force` returns to 0, the line shows the bit that the frame has reached, and the frame ends after the same number of ticks as it would without the break.
- R12: `par_en`, `par_sel` and `tx_data` are sampled at acceptance. Changing them during a frame has no effect on that frame.
- R13: The frame advances only on cycles where `baud_tick` is 1. Between ticks, the transmitted bit does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse marking a bit-period boundary |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` holds a byte to send |
| tx_ready | output | 1 | Block is idle and will take a byte |
| par_en | input | 1 | 1 = append a parity bit |
| par_sel | input | 2 | Parity mode: 0 odd, 1 even, 2 forced 1, 3 forced 0 |
| brk_force | input | 1 | 1 = hold the line low |
| txd | output | 1 | Serial output line, high when idle |

## Verification
The checker module tests these rules on every cycle:
- the break input always wins over the line;
- an idle block always shows a high line;
- acceptance always gives a start bit and a busy block on the next cycle;
- the frame position and the captured line control never move between baud ticks;
- ending a stop bit always returns the block to ready.

Only the bench's scenarios can show that the right bits come out in the right order. That covers the data bits in order, the parity value in each of the four modes, the bit count with and without parity, and a frame picking up at the correct position after a break is released. The bench checks these against frames it builds itself from the byte and the mode.

// File: rtl/tx_line_pkg.sv
package tx_line_pkg;

  // Frame sequencer states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  // Parity mode encoding carried on par_sel
  typedef enum logic [1:0] {
    PAR_ODD   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_MARK  = 2'd2,
    PAR_SPACE = 2'd3
  } par_mode_e;

  // Line-control word captured at acceptance
  typedef struct packed {
    logic      par_en;
    par_mode_e par_mode;
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{par_en: 1'b0, par_mode: PAR_ODD};

  // Serial level for a state that does not carry a data or parity bit
  function automatic logic fixed_level(input tx_state_e st);
    return (st == ST_START) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/tx_parity_gen.sv
module tx_parity_gen
  import tx_line_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_in,
  input  par_mode_e         mode,
  output logic              par_bit
);

  // Reduction XOR is 1 when the data holds an odd number of ones
  function automatic logic calc_parity(input logic [DATA_W-1:0] d, input par_mode_e m);
    logic odd_ones;
    odd_ones = ^d;
    case (m)
      PAR_ODD:   return ~odd_ones;
      PAR_EVEN:  return odd_ones;
      PAR_MARK:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

  assign par_bit = calc_parity(data_in, mode);

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tx_line_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  line_cfg_t         cfg_in,
  input  logic              par_in,
  output logic              tx_ready,
  output logic              ser_bit,
  output logic              accept_evt,
  output logic              frame_done_evt,
  output tx_state_e         state_o,
  output logic [$clog2(DATA_W)-1:0] bit_idx_o,
  output line_cfg_t         cfg_o
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  line_cfg_t         cfg_q;
  logic              par_q;

  assign tx_ready       = (state_q == ST_IDLE);
  assign accept_evt     = tx_valid && tx_ready;
  assign frame_done_evt = (state_q == ST_STOP) && baud_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
      cfg_q   <= CFG_RESET;
      par_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            shreg_q <= tx_data;
            cfg_q   <= cfg_in;
            par_q   <= par_in;
            idx_q   <= '0;
            state_q <= ST_START;
          end
        end
        ST_START: begin
          if (baud_tick) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (baud_tick) begin
            shreg_q <= shreg_q >> 1;
            if (idx_q == LAST_IDX) begin
              idx_q   <= '0;
              state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (baud_tick) state_q <= ST_STOP;
        end
        ST_STOP: begin
          if (baud_tick) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_DATA: ser_bit = shreg_q[0];
      ST_PAR:  ser_bit = par_q;
      default: ser_bit = fixed_level(state_q);
    endcase
  end

  assign state_o   = state_q;
  assign bit_idx_o = idx_q;
  assign cfg_o     = cfg_q;

endmodule

// File: rtl/tx_line_drive.sv
module tx_line_drive (
  input  logic ser_bit,
  input  logic brk_force,
  output logic txd
);

  // Break overrides the sequencer output unconditionally
  assign txd = brk_force ? 1'b0 : ser_bit;

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import tx_line_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              par_en,
  input  logic [1:0]        par_sel,
  input  logic              brk_force,
  output logic              txd
);

  localparam int IDX_W = $clog2(DATA_W);

  line_cfg_t        cfg_in;
  line_cfg_t        cfg_q;
  logic             par_bit;
  logic             ser_bit;
  logic             accept_evt;
  logic             frame_done_evt;
  tx_state_e        seq_state;
  logic [IDX_W-1:0] seq_idx;
  logic [IDX_W+2:0] pos_code;

  assign cfg_in.par_en   = par_en;
  assign cfg_in.par_mode = par_mode_e'(par_sel);
  assign pos_code        = {seq_state, seq_idx};

  tx_parity_gen #(.DATA_W(DATA_W)) u_par (
    .data_in (tx_data),
    .mode    (cfg_in.par_mode),
    .par_bit (par_bit)
  );

  tx_frame_seq #(.DATA_W(DATA_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .baud_tick      (baud_tick),
    .tx_data        (tx_data),
    .tx_valid       (tx_valid),
    .cfg_in         (cfg_in),
    .par_in         (par_bit),
    .tx_ready       (tx_ready),
    .ser_bit        (ser_bit),
    .accept_evt     (accept_evt),
    .frame_done_evt (frame_done_evt),
    .state_o        (seq_state),
    .bit_idx_o      (seq_idx),
    .cfg_o          (cfg_q)
  );

  tx_line_drive u_drv (
    .ser_bit   (ser_bit),
    .brk_force (brk_force),
    .txd       (txd)
  );

endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk #(
  parameter int POS_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             baud_tick,
  input logic             tx_ready,
  input logic             brk_force,
  input logic             txd,
  input logic             accept_evt,
  input logic             frame_done_evt,
  input logic [POS_W-1:0] pos_code,
  input logic [2:0]       cfg_bits
);

  // R10
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_force |-> !txd);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !brk_force) |-> txd);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !tx_ready);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (!txd || brk_force));

  // R13
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !tx_ready) |=> $stable(pos_code));

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |=> $stable(cfg_bits));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_evt |=> tx_ready);

endmodule

bind serial_tx_core serial_tx_chk #(.POS_W(IDX_W + 3)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .baud_tick      (baud_tick),
  .tx_ready       (tx_ready),
  .brk_force      (brk_force),
  .txd            (txd),
  .accept_evt     (accept_evt),
  .frame_done_evt (frame_done_evt),
  .pos_code       (pos_code),
  .cfg_bits       (cfg_q)
);

// File: tb/sim_serial_tx_core.sv
`timescale 1ns/1ps
module sim_serial_tx_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       par_en = 1'b0;
  logic [1:0] par_sel = 2'd0;
  logic       brk_force = 1'b0;
  logic       txd;

  int n_chk = 0;
  int n_bad = 0;
  int tick_cnt = 0;

  always #5 clk = ~clk;

  // Baud tick every fourth cycle, driven at the falling edge
  always @(negedge clk) begin
    tick_cnt  = (tick_cnt + 1) % 4;
    baud_tick = (tick_cnt == 3);
  end

  serial_tx_core u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .par_en(par_en),
    .par_sel(par_sel), .brk_force(brk_force), .txd(txd)
  );

  // Vector format {data[7:0], par_en, par_sel[1:0]}
  localparam logic [10:0] VEC [10] = '{
    {8'hA5, 1'b1, 2'd0}, {8'hA5, 1'b1, 2'd1}, {8'h01, 1'b1, 2'd0},
    {8'h01, 1'b1, 2'd1}, {8'h3C, 1'b1, 2'd2}, {8'h3C, 1'b1, 2'd3},
    {8'hFF, 1'b1, 2'd2}, {8'h00, 1'b1, 2'd3}, {8'h96, 1'b0, 2'd1},
    {8'h7E, 1'b0, 2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic ref_parity(input logic [7:0] d, input logic [1:0] ps);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    case (ps)
      2'd0: return (ones % 2 == 0);
      2'd1: return (ones % 2 == 1);
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Send one frame and check it; break is held during ticks [bs, be)
  task automatic run_frame(input logic [7:0] d, input logic pe, input logic [1:0] ps,
                           input int bs, input int be, input bit twist);
    logic exp_bits [11];
    logic got_bits [11];
    int nbits, ticks;
    logic prev_txd, prev_tick, prev_brk, first;
    bit bad_hold, bad_brk, bad_ready;
    string preq;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) exp_bits[i+1] = d[i];
    nbits = pe ? 11 : 10;
    if (pe) exp_bits[9] = ref_parity(d, ps);
    exp_bits[nbits-1] = 1'b1;

    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; par_en = pe; par_sel = ps; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    if (twist) begin
      // R12: change all captured inputs mid-frame
      tx_data = ~d; par_en = ~pe; par_sel = ps + 2'd1;
    end
    ticks = 0; first = 1'b1; prev_txd = 1'b0; prev_tick = 1'b0; prev_brk = 1'b0;
    bad_hold = 0; bad_brk = 0; bad_ready = 0;
    while (ticks < nbits) begin
      brk_force = (ticks >= bs) && (ticks < be);
      #1;
      if (tx_ready) bad_ready = 1;
      if (brk_force && txd) bad_brk = 1;
      if (!first && !prev_tick && !brk_force && !prev_brk && (txd !== prev_txd)) bad_hold = 1;
      if (baud_tick) begin
        got_bits[ticks] = txd;
        ticks++;
      end
      prev_txd = txd; prev_tick = baud_tick; prev_brk = brk_force; first = 1'b0;
      @(negedge clk);
    end
    brk_force = 1'b0;
    #1;
    chk("R2 ready low during frame", 32'(bad_ready), 0);
    chk("R13 bit held between ticks", 32'(bad_hold), 0);
    if (be > bs) chk("R10 line low under break", 32'(bad_brk), 0);
    for (int k = 0; k < nbits; k++) begin
      logic e;
      e = ((k >= bs) && (k < be)) ? 1'b0 : exp_bits[k];
      if (k == 0) chk("R3 start bit", 32'(got_bits[k]), 32'(e));
      else if (k <= 8) chk((be > bs) ? "R11 data bit after break" : "R3 data bit", 32'(got_bits[k]), 32'(e));
      else if (k == nbits - 1) chk("R9 stop bit", 32'(got_bits[k]), 32'(e));
      else begin
        case (ps)
          2'd0: preq = "R5 odd parity";
          2'd1: preq = "R6 even parity";
          2'd2: preq = "R7 forced-1 parity";
          default: preq = "R8 forced-0 parity";
        endcase
        chk(preq, 32'(got_bits[k]), 32'(e));
      end
    end
    if (!pe) chk("R4 ready after 10 bits, no parity", 32'(tx_ready), 1);
    else     chk("R9 ready after stop", 32'(tx_ready), 1);
    chk("R9 idle line high", 32'(txd), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 32'(tx_ready), 1);
    chk("R1 reset line high", 32'(txd), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle ready", 32'(tx_ready), 1);
    chk("R1 idle line", 32'(txd), 1);

    for (int v = 0; v < 10; v++)
      run_frame(VEC[v][10:3], VEC[v][2], VEC[v][1:0], 99, 0, 1'b0);

    // R12: captured inputs altered mid-frame
    run_frame(8'hC3, 1'b1, 2'd0, 99, 0, 1'b1);
    run_frame(8'h5A, 1'b0, 2'd3, 99, 0, 1'b1);

    // R10/R11: break over bits 2..5 of a parity frame, then released
    run_frame(8'hB2, 1'b1, 2'd1, 2, 6, 1'b0);
    run_frame(8'h4D, 1'b1, 2'd2, 7, 10, 1'b0);

    // R10: break while idle
    @(negedge clk);
    brk_force = 1'b1;
    for (int c = 0; c < 5; c++) begin
      #1 chk("R10 idle break low", 32'(txd), 0);
      @(negedge clk);
    end
    chk("R10 idle break keeps ready", 32'(tx_ready), 1);
    brk_force = 1'b0;
    #1 chk("R10 line restored after break", 32'(txd), 1);

    // R1: reset mid-frame returns to idle
    tx_data = 8'h11; par_en = 1'b1; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset mid-frame ready", 32'(tx_ready), 1);
    chk("R1 reset mid-frame line", 32'(txd), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule